// File: doc/BRIEF.md
# Codec SPI Configuration Sequencer

This block brings an audio codec out of its power-on control mode and loads its register settings over SPI, with no processor involvement. Every transaction is a four-byte frame. The first byte carries a seven-bit device identifier and a direction flag. The next two bytes carry a 16-bit register address, high byte first. The last byte is either the value to write or, for a read, a dummy byte sent while the codec's answer is shifted in.

After reset the sequencer does three things in order. First, it issues a fixed number of throw-away reads of a mode register. Each read shows up as its own select pulse, and these pulses switch the codec into SPI mode. Second, it reads the same register once more and compares the answer with the expected value. Third, if the answer matches, it writes a parameterized list of address/data pairs. It ends in either a done state or a fail state, and that state holds until the next reset.

Bit-level shifting is handled by a separate byte engine. The sequencer presents a byte with a one-cycle request and then waits for that engine's completion strobe, which carries the received byte. The sequencer itself owns the active-low select line and keeps it high for a minimum number of cycles between frames.

Top module: `codec_cfg_seq`

## Requirements
- R1: While reset is asserted, `spi_sel_n` is 1, `spi_tx_req` is 0, and both `cfg_done` and `cfg_fail` are 0.
- R2: Each frame is a single low window of `spi_sel_n` that contains exactly four byte requests. A new request is raised only after `spi_rx_done` has answered the previous one.
- R3: The first byte of a frame is `{CHIP_ID[6:0], rw}`. Bit 0 (`rw`) is 1 for a read and 0 for a write.
- R4: The second and third bytes are the register address, high byte then low byte. The fourth byte is the write data for a write and 8'h00 for a read.
- R5: The first MODE_READS frames (default 3) are reads of MODE_ADDR (default 16'h4000). The data returned by these reads has no effect on the sequence.
- R6: The next frame is a read of MODE_ADDR. The byte received with the fourth `spi_rx_done` of that frame is compared with MODE_EXPECT (default 8'h01).
- R7: If that byte differs from MODE_EXPECT, `cfg_fail` rises and no further frame is issued.
- R8: If that byte matches, one write frame is issued per list entry, in ascending index order. Entry i occupies bits [24*i+23 : 24*i] of WR_LIST, with the address in entry bits [23:8] and the data in entry bits [7:0].
- R9: When the last write frame has ended, `cfg_done` rises.
- R10: `cfg_done` and `cfg_fail` are never high together. Each stays high until reset, and no byte request is made while either one is high.
- R11: Between two frames, `spi_sel_n` stays high for at least GAP_CYCLES clock cycles.
- R12: `spi_tx_req` is a single-cycle pulse and is only raised while `spi_sel_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sel_n | output | 1 | Active-low codec select, low for the whole of a frame |
| spi_tx_req | output | 1 | One-cycle request to the byte engine to shift `spi_tx_byte` |
| spi_tx_byte | output | 8 | Byte to transmit, valid while the frame is open |
| spi_rx_done | input | 1 | One-cycle completion strobe from the byte engine |
| spi_rx_byte | input | 8 | Byte received during the completed transfer |
| cfg_done | output | 1 | Sticky: the whole sequence finished with a good read-back |
| cfg_fail | output | 1 | Sticky: the read-back value was wrong |

## Verification
A wrong sequencer state becomes visible on the select line and in the byte stream within one frame. A mode-read counter that is off by one changes the number of read frames. A write index that skips or repeats shows up as a wrong or repeated address in the next write frame. A broken compare shows up as a wrong `cfg_done`/`cfg_fail` outcome, which appears no later than one gap after the verify frame ends. The bench sweeps every possible read-back value, so the compare is tested on all 256 inputs. For each run it checks every byte of every recorded frame, plus the frame count and the select gaps.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;

  // one register-list entry: {address[15:0], data[7:0]}
  localparam int ENTRY_W = 24;
  localparam int FRAME_BYTES = 4;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_MODESW,
    SQ_VERIFY,
    SQ_WRITE,
    SQ_DONE,
    SQ_FAIL
  } seq_state_t;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_SEND,
    FR_WAIT,
    FR_GAP
  } frm_state_t;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/cfg_gap_timer.sv
module cfg_gap_timer #(
  parameter int GAP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int CNT_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = run || (cnt_q != '0);
    cnt_d  = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run && (cnt_q == CNT_LAST);

endmodule

// File: rtl/cfg_frame_pack.sv
module cfg_frame_pack #(
  parameter logic [6:0] CHIP_ID = 7'h00
) (
  input  logic        rw,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic [1:0]  idx,
  output logic [7:0]  byte_o
);

  always_comb begin
    unique case (idx)
      2'd0:    byte_o = {CHIP_ID, rw};
      2'd1:    byte_o = addr[15:8];
      2'd2:    byte_o = addr[7:0];
      default: byte_o = rw ? 8'h00 : wdata;
    endcase
  end

endmodule

// File: rtl/cfg_frame_engine.sv
module cfg_frame_engine
  import codec_cfg_pkg::*;
#(
  parameter logic [6:0] CHIP_ID    = 7'h00,
  parameter int         GAP_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rw,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic        ready,
  output logic        frame_end,
  output logic [7:0]  rd_data,
  output logic        sel_n,
  output logic        tx_req,
  output logic [7:0]  tx_byte,
  input  logic        rx_done,
  input  logic [7:0]  rx_byte
);

  localparam logic [1:0] LAST_IDX = 2'(FRAME_BYTES - 1);

  frm_state_t  fs_q, fs_d;
  logic [1:0]  bi_q, bi_d;
  logic        bi_en;
  logic        hdr_en;
  logic        rw_q;
  logic [15:0] addr_q;
  logic [7:0]  data_q;
  logic        rd_en;
  logic [7:0]  rd_q;
  logic        gap_run;
  logic        gap_exp;

  cfg_frame_pack #(.CHIP_ID(CHIP_ID)) u_pack (
    .rw     (rw_q),
    .addr   (addr_q),
    .wdata  (data_q),
    .idx    (bi_q),
    .byte_o (tx_byte)
  );

  cfg_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (gap_run),
    .expired (gap_exp)
  );

  // next-state
  always_comb begin
    fs_d   = fs_q;
    bi_d   = bi_q;
    bi_en  = 1'b0;
    hdr_en = 1'b0;
    rd_en  = 1'b0;
    unique case (fs_q)
      FR_IDLE: begin
        if (start) begin
          hdr_en = 1'b1;
          bi_en  = 1'b1;
          bi_d   = 2'd0;
          fs_d   = FR_SEND;
        end
      end
      FR_SEND: fs_d = FR_WAIT;
      FR_WAIT: begin
        if (rx_done) begin
          if (bi_q == LAST_IDX) begin
            rd_en = 1'b1;
            fs_d  = FR_GAP;
          end else begin
            bi_en = 1'b1;
            bi_d  = bi_q + 2'd1;
            fs_d  = FR_SEND;
          end
        end
      end
      default: begin
        if (gap_exp) fs_d = FR_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q <= FR_IDLE;
    end else if (fs_d != fs_q) begin
      fs_q <= fs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bi_q <= 2'd0;
    end else if (bi_en) begin
      bi_q <= bi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q   <= 1'b1;
      addr_q <= 16'h0000;
      data_q <= 8'h00;
    end else if (hdr_en) begin
      rw_q   <= rw;
      addr_q <= addr;
      data_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 8'h00;
    end else if (rd_en) begin
      rd_q <= rx_byte;
    end
  end

  assign ready     = (fs_q == FR_IDLE);
  assign tx_req    = (fs_q == FR_SEND);
  assign sel_n     = !((fs_q == FR_SEND) || (fs_q == FR_WAIT));
  assign gap_run   = (fs_q == FR_GAP);
  assign frame_end = gap_exp;
  assign rd_data   = rd_q;

endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
  import codec_cfg_pkg::*;
#(
  parameter logic [6:0]  CHIP_ID     = 7'h00,
  parameter logic [15:0] MODE_ADDR   = 16'h4000,
  parameter logic [7:0]  MODE_EXPECT = 8'h01,
  parameter int          MODE_READS  = 3,
  parameter int          GAP_CYCLES  = 4,
  parameter int          NUM_WR      = 2,
  parameter logic [NUM_WR*ENTRY_W-1:0] WR_LIST = {24'h4015_01, 24'h4000_01}
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       spi_sel_n,
  output logic       spi_tx_req,
  output logic [7:0] spi_tx_byte,
  input  logic       spi_rx_done,
  input  logic [7:0] spi_rx_byte,
  output logic       cfg_done,
  output logic       cfg_fail
);

  localparam int RD_W = $clog2(MODE_READS + 1);
  localparam int WI_W = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;
  localparam logic [RD_W-1:0] RD_LAST = RD_W'(MODE_READS - 1);
  localparam logic [WI_W-1:0] WI_LAST = WI_W'(NUM_WR - 1);

  logic                srst_n;
  seq_state_t          st_q, st_d;
  logic [RD_W-1:0]     rd_cnt_q, rd_cnt_d;
  logic                rd_cnt_en;
  logic [WI_W-1:0]     widx_q, widx_d;
  logic                widx_en;
  logic [ENTRY_W-1:0]  wr_entry;
  logic                frm_rw;
  logic [15:0]         frm_addr;
  logic [7:0]          frm_data;
  logic                launch;
  logic                eng_ready;
  logic                eng_end;
  logic [7:0]          eng_rd;

  cfg_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cfg_frame_engine #(
    .CHIP_ID    (CHIP_ID),
    .GAP_CYCLES (GAP_CYCLES)
  ) u_eng (
    .clk       (clk),
    .rst_n     (srst_n),
    .start     (launch),
    .rw        (frm_rw),
    .addr      (frm_addr),
    .wdata     (frm_data),
    .ready     (eng_ready),
    .frame_end (eng_end),
    .rd_data   (eng_rd),
    .sel_n     (spi_sel_n),
    .tx_req    (spi_tx_req),
    .tx_byte   (spi_tx_byte),
    .rx_done   (spi_rx_done),
    .rx_byte   (spi_rx_byte)
  );

  assign wr_entry = WR_LIST[int'(widx_q)*ENTRY_W +: ENTRY_W];

  // frame fields and launch
  always_comb begin
    frm_rw   = 1'b1;
    frm_addr = MODE_ADDR;
    frm_data = 8'h00;
    if (st_q == SQ_WRITE) begin
      frm_rw   = 1'b0;
      frm_addr = wr_entry[23:8];
      frm_data = wr_entry[7:0];
    end
    launch = eng_ready &&
             ((st_q == SQ_MODESW) || (st_q == SQ_VERIFY) || (st_q == SQ_WRITE));
  end

  // next-state
  always_comb begin
    st_d      = st_q;
    rd_cnt_d  = rd_cnt_q;
    rd_cnt_en = 1'b0;
    widx_d    = widx_q;
    widx_en   = 1'b0;
    unique case (st_q)
      SQ_IDLE: st_d = SQ_MODESW;
      SQ_MODESW: begin
        if (eng_end) begin
          if (rd_cnt_q == RD_LAST) begin
            st_d = SQ_VERIFY;
          end else begin
            rd_cnt_en = 1'b1;
            rd_cnt_d  = rd_cnt_q + 1'b1;
          end
        end
      end
      SQ_VERIFY: begin
        if (eng_end) begin
          st_d = (eng_rd == MODE_EXPECT) ? SQ_WRITE : SQ_FAIL;
        end
      end
      SQ_WRITE: begin
        if (eng_end) begin
          if (widx_q == WI_LAST) begin
            st_d = SQ_DONE;
          end else begin
            widx_en = 1'b1;
            widx_d  = widx_q + 1'b1;
          end
        end
      end
      default: st_d = st_q;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= SQ_IDLE;
    end else if (st_d != st_q) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_cnt_q <= '0;
    end else if (rd_cnt_en) begin
      rd_cnt_q <= rd_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      widx_q <= '0;
    end else if (widx_en) begin
      widx_q <= widx_d;
    end
  end

  assign cfg_done = (st_q == SQ_DONE);
  assign cfg_fail = (st_q == SQ_FAIL);

endmodule

// File: rtl/codec_cfg_seq_chk.sv
module codec_cfg_seq_chk #(
  parameter int GAP_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic spi_sel_n,
  input logic spi_tx_req,
  input logic cfg_done,
  input logic cfg_fail
);

  localparam int HW = $clog2(GAP_CYCLES + 1);
  localparam logic [HW-1:0] HSAT = HW'(GAP_CYCLES);

  logic [HW-1:0] hi_cnt;
  logic          seen_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt     <= '0;
      seen_frame <= 1'b0;
    end else if (!spi_sel_n) begin
      hi_cnt     <= '0;
      seen_frame <= 1'b1;
    end else if (hi_cnt != HSAT) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  a_r12_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_req |=> !spi_tx_req);

  a_r12_req_in_sel: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_req |-> !spi_sel_n);

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fail |=> cfg_fail);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_done && cfg_fail));

  a_r10_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done || cfg_fail) |-> (!spi_tx_req && spi_sel_n));

  a_r11_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_frame && $fell(spi_sel_n)) |-> (hi_cnt == HSAT));

endmodule

bind codec_cfg_seq codec_cfg_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_sel_n  (spi_sel_n),
  .spi_tx_req (spi_tx_req),
  .cfg_done   (cfg_done),
  .cfg_fail   (cfg_fail)
);

// File: tb/test_codec_cfg_seq.sv
module test_codec_cfg_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;
  localparam int GAP        = 3;
  localparam int NW         = 3;
  localparam int NREAD      = 3;
  localparam logic [6:0]  ID   = 7'h2B;
  localparam logic [15:0] MADR = 16'h4000;
  localparam logic [NW*24-1:0] LIST = {24'h40F9_C3, 24'h400A_7E, 24'h4015_01};

  logic       clk;
  logic       rst_n;
  logic       spi_sel_n;
  logic       spi_tx_req;
  logic [7:0] spi_tx_byte;
  logic       spi_rx_done;
  logic [7:0] spi_rx_byte;
  logic       cfg_done;
  logic       cfg_fail;

  codec_cfg_seq #(
    .CHIP_ID    (ID),
    .MODE_ADDR  (MADR),
    .MODE_EXPECT(8'h01),
    .MODE_READS (NREAD),
    .GAP_CYCLES (GAP),
    .NUM_WR     (NW),
    .WR_LIST    (LIST)
  ) i_codec_cfg_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sel_n   (spi_sel_n),
    .spi_tx_req  (spi_tx_req),
    .spi_tx_byte (spi_tx_byte),
    .spi_rx_done (spi_rx_done),
    .spi_rx_byte (spi_rx_byte),
    .cfg_done    (cfg_done),
    .cfg_fail    (cfg_fail)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;

  // byte engine / codec model state
  logic [7:0] verify_val;
  logic [7:0] fb [8][4];
  int         fcnt [8];
  int         frames, bcnt, pend, req_cnt, bad_req, min_gap, gap;
  logic [7:0] reply;
  logic       sel_prev;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // byte engine and frame recorder, acting on falling edges
  initial begin
    spi_rx_done = 1'b0;
    spi_rx_byte = 8'h00;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        spi_rx_done = 1'b0;
        frames = 0; bcnt = 0; pend = 0; req_cnt = 0; bad_req = 0;
        min_gap = 1000; gap = 0; sel_prev = 1'b1;
        continue;
      end
      spi_rx_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          spi_rx_done = 1'b1;
          spi_rx_byte = reply;
        end
      end
      if (spi_tx_req) begin
        if (spi_sel_n) bad_req++;
        if (frames < 8 && bcnt < 4) fb[frames][bcnt] = spi_tx_byte;
        if (bcnt == 3) reply = (frames < NREAD) ? 8'hA5 : (frames == NREAD) ? verify_val : 8'h00;
        else           reply = 8'h5A;
        bcnt++;
        req_cnt++;
        pend = LAT;
      end
      if (!sel_prev && spi_sel_n) begin
        if (frames < 8) fcnt[frames] = bcnt;
        frames++;
        bcnt = 0;
        gap = 0;
      end
      if (spi_sel_n) gap++;
      if (sel_prev && !spi_sel_n && frames > 0 && gap < min_gap) min_gap = gap;
      sel_prev = spi_sel_n;
    end
  end

  task automatic run_case(input logic [7:0] v);
    int to;
    int nexp;
    logic [23:0] e;
    logic        good;
    good = (v == 8'h01);
    nexp = good ? NREAD + 1 + NW : NREAD + 1;
    rst_n = 1'b0;
    verify_val = v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "sel_n in reset", int'(spi_sel_n), 1);
    chk("R1", "tx_req in reset", int'(spi_tx_req), 0);
    chk("R1", "done in reset", int'(cfg_done), 0);
    chk("R1", "fail in reset", int'(cfg_fail), 0);
    rst_n = 1'b1;
    to = 0;
    while (!(cfg_done || cfg_fail) && to < 3000) begin
      @(negedge clk);
      to++;
    end
    repeat (40) @(negedge clk);
    // R9 / R7 / R10: outcome, held after 40 idle cycles
    chk(good ? "R9" : "R7", "done", int'(cfg_done), good ? 1 : 0);
    chk(good ? "R9" : "R7", "fail", int'(cfg_fail), good ? 0 : 1);
    chk("R10", "frame count", frames, nexp);
    chk("R2", "requests", req_cnt, 4 * frames);
    chk("R12", "req outside select", bad_req, 0);
    chk("R11", "gap short", int'(min_gap >= GAP), 1);
    for (int f = 0; f < nexp && f < 8; f++) begin
      chk("R2", "bytes per frame", fcnt[f], 4);
      if (f < NREAD + 1) begin
        chk("R3", "read header", int'(fb[f][0]), int'({ID, 1'b1}));
        chk(f < NREAD ? "R5" : "R6", "addr hi", int'(fb[f][1]), int'(MADR[15:8]));
        chk(f < NREAD ? "R5" : "R6", "addr lo", int'(fb[f][2]), int'(MADR[7:0]));
        chk("R4", "read dummy", int'(fb[f][3]), 0);
      end else begin
        e = LIST[(f - NREAD - 1)*24 +: 24];
        chk("R3", "write header", int'(fb[f][0]), int'({ID, 1'b0}));
        chk("R8", "write addr hi", int'(fb[f][1]), int'(e[23:16]));
        chk("R8", "write addr lo", int'(fb[f][2]), int'(e[15:8]));
        chk("R4", "write data", int'(fb[f][3]), int'(e[7:0]));
      end
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    rst_n = 1'b0;
    verify_val = 8'h00;
    for (int v = 0; v < 256; v++) run_case(8'(v));
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule